// File: doc/BRIEF.md
# Two-Stage SCK Prescaler

This block produces the serial clock of an SPI master from the system clock. A primary stage divides by 1, 4, 16 or 64, and a secondary stage in cascade behind it divides by 1 to 8. One SCK period therefore lasts as many system clocks as the product of the two ratios. Next to the SCK level, the block issues single-cycle strobes for the shift logic. The leading strobe marks the move from the idle level to the active level, and the trailing strobe marks the move back. The shift logic is not part of this block.

A transfer runs in one of two ways. In the gated way, a start request produces exactly 8 or 16 pulses and then stops. In the framed way, the generator runs without pause while the framed request is held and signals each completed word. A halt input stands for sleep, or for idle with stop-in-idle. It aborts the transfer and returns everything to rest. An external-clock option turns off the SCK drive. The strobes are then taken from synchronised edges of an SCK that another device supplies.

Top module: `sck_prescaler`

## Requirements
- R1: The SCK period is P*S system clocks. P is 64, 16, 4 or 1 for `pri_code` 0, 1, 2 or 3. S is 8 minus `sec_code`, so code 7 gives 1 and code 0 gives 8.
- R2: When P*S would be 1, meaning `pri_code`=3 and `sec_code`=7, the period is 2 clocks, with one clock at each level.
- R3: Each period starts with a leading edge. The active level then lasts floor(P*S/2) clocks and the idle level lasts the rest, so with an odd product the active phase is one clock shorter. `lead_stb` is high in the cycle in which `sck_out` first shows the active level. `trail_stb` is high in the cycle in which it first shows the idle level again.
- R4: `sck_out` equals `cpol` whenever no SCK pulse is active. During a pulse it is the inverse of `cpol`.
- R5: In gated mode, a `start` sampled while idle makes the first leading edge appear one cycle later. Exactly 8 pulses follow when `word16`=0, or 16 when it is 1. In the cycle that shows the last trailing edge, `word_done` pulses and `busy` falls.
- R6: A `start` that arrives while `busy` is high has no effect on the running word.
- R7: While `framed` is held, SCK runs without pause, and `word_done` pulses with every 8th or 16th trailing edge. After `framed` drops, the generator stops at the next trailing edge.
- R8: One cycle after `halt` is sampled high, `busy`, the strobes and `word_done` are low and SCK is idle. `start` is ignored while `halt` is high. The next word after release has full, fresh timing.
- R9: If `halt` is sampled in the cycle whose trailing edge would finish the word, then neither that trailing strobe nor `word_done` appears.
- R10: With `ext_clk_en`=1, `sck_oe` is 0 and `sck_out` stays at `cpol`. Leading and trailing strobes follow the idle-to-active and active-to-idle edges of `sck_in`, after a two-flop synchroniser, and the pulse count and `word_done` work as in R5.
- R11: Edges on `sck_in` while `busy` is low produce no strobe.
- R12: `lead_stb` and `trail_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_code | input | 2 | Primary ratio code (3 = fastest) |
| sec_code | input | 3 | Secondary ratio code (7 = fastest) |
| cpol | input | 1 | Idle level of SCK |
| word16 | input | 1 | 1 = 16 pulses per word, 0 = 8 |
| start | input | 1 | Gated transfer request |
| framed | input | 1 | Continuous-run request |
| halt | input | 1 | Stop and reset the generator |
| ext_clk_en | input | 1 | Use the external SCK instead of the generated one |
| sck_in | input | 1 | External SCK |
| sck_out | output | 1 | Generated SCK level |
| sck_oe | output | 1 | SCK drive enable |
| lead_stb | output | 1 | Idle-to-active edge strobe |
| trail_stb | output | 1 | Active-to-idle edge strobe |
| word_done | output | 1 | Word completed pulse |
| busy | output | 1 | Generator running |

## Verification
The halt request and the final trailing edge of a word can fall in the same cycle. The bench provokes this by raising `halt` exactly one cycle before the cycle that would show the last trailing strobe, for a divide-by-8 word. It then requires that the cycle carries no trailing strobe and no `word_done`, and that `busy` is already low. A second coincidence, a `start` arriving in the middle of a running word, is judged by requiring that the word's full strobe and SCK timeline stays unchanged.

// File: rtl/sck_prescaler_pkg.sv
`timescale 1ns/1ps
package sck_prescaler_pkg;
  localparam int PRI_W    = 2;
  localparam int SEC_W    = 3;
  localparam int PRI_STEP = 2;
  localparam int PCNT_W   = PRI_STEP * ((1 << PRI_W) - 1);
  localparam int SH_W     = $clog2(PCNT_W + 1);
  localparam int SRAT_W   = SEC_W + 1;
  localparam int POS_W    = PCNT_W + SEC_W;

  function automatic logic [SH_W-1:0] pri_shift(input logic [PRI_W-1:0] code);
    return SH_W'(PRI_STEP * (((1 << PRI_W) - 1) - int'(code)));
  endfunction
endpackage

// File: rtl/sckp_pri_div.sv
`timescale 1ns/1ps
module sckp_pri_div
  import sck_prescaler_pkg::*;
#(
  parameter int CW = PCNT_W,
  parameter int SW = SH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [SW-1:0] shift,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] cnt_q, cnt_d, last_v;

  assign last_v = ~({CW{1'b1}} << shift);
  assign wrap   = (cnt_q == last_v);
  assign cnt    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (en)   cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sckp_sec_div.sv
`timescale 1ns/1ps
module sckp_sec_div
  import sck_prescaler_pkg::*;
#(
  parameter int CW = SEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [CW:0]   ratio,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   last_w;
  logic          wrap;

  assign last_w = ratio - (CW+1)'(1);
  assign wrap   = ({1'b0, cnt_q} == last_w);
  assign cnt    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sckp_ext_sync.sv
`timescale 1ns/1ps
module sckp_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic cpol,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe_q, pipe_d;
  logic            act_now, act_prev;

  assign pipe_d   = {pipe_q[STAGES-1:0], sck_in};
  assign act_now  = pipe_q[STAGES-1] ^ cpol;
  assign act_prev = pipe_q[STAGES] ^ cpol;
  assign rise     = act_now & ~act_prev;
  assign fall     = ~act_now & act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end
endmodule

// File: rtl/sck_prescaler.sv
`timescale 1ns/1ps
module sck_prescaler
  import sck_prescaler_pkg::*;
#(
  parameter int SHORT_BITS  = 8,
  parameter int LONG_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRI_W-1:0] pri_code,
  input  logic [SEC_W-1:0] sec_code,
  input  logic             cpol,
  input  logic             word16,
  input  logic             start,
  input  logic             framed,
  input  logic             halt,
  input  logic             ext_clk_en,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             word_done,
  output logic             busy
);
  localparam int CNT_W = $clog2(LONG_BITS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // ratio decode
  logic [SH_W-1:0]   shift;
  logic [SRAT_W-1:0] s_raw, s_eff;
  logic [POS_W:0]    full_w;
  logic [POS_W-1:0]  half, pos;
  assign shift  = pri_shift(pri_code);
  assign s_raw  = SRAT_W'(1 << SEC_W) - {1'b0, sec_code};
  assign s_eff  = (shift == '0 && s_raw == SRAT_W'(1)) ? SRAT_W'(2) : s_raw;
  assign full_w = (POS_W+1)'(s_eff) << shift;
  assign half   = full_w[POS_W:1];

  // state
  logic             run_q, run_d, fr_q, fr_d, act_q, act_d;
  logic             lead_q, lead_d, trail_q, trail_d, done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, bits_m1;
  logic             stop_now, cnt_en, cnt_clr;
  logic [PCNT_W-1:0] pc;
  logic [SEC_W-1:0]  sc;
  logic              pri_wrap, ext_rise, ext_fall;
  logic              lead_ev, trail_ev, last_pulse;

  assign cnt_en  = run_q & ~ext_clk_en;
  assign cnt_clr = halt | ~run_q | stop_now;

  sckp_pri_div #(.CW(PCNT_W), .SW(SH_W)) u_pri (
    .clk(clk), .rst_n(rst_i), .en(cnt_en), .clr(cnt_clr),
    .shift(shift), .cnt(pc), .wrap(pri_wrap)
  );

  sckp_sec_div #(.CW(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_i), .en(cnt_en & pri_wrap), .clr(cnt_clr),
    .ratio(s_eff), .cnt(sc)
  );

  sckp_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .sck_in(sck_in), .cpol(cpol),
    .rise(ext_rise), .fall(ext_fall)
  );

  assign pos        = (POS_W'(sc) << shift) | POS_W'(pc);
  assign lead_ev    = run_q & (ext_clk_en ? ext_rise : (pos == '0));
  assign trail_ev   = run_q & (ext_clk_en ? ext_fall : (pos == half));
  assign bits_m1    = word16 ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1);
  assign last_pulse = (cnt_q == bits_m1);

  always_comb begin
    run_d    = run_q;
    fr_d     = fr_q;
    act_d    = act_q;
    cnt_d    = cnt_q;
    lead_d   = 1'b0;
    trail_d  = 1'b0;
    done_d   = 1'b0;
    stop_now = 1'b0;
    if (halt) begin
      run_d = 1'b0;
      fr_d  = 1'b0;
      act_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q) begin
      if (framed || start) begin
        run_d = 1'b1;
        fr_d  = framed;
        act_d = 1'b0;
        cnt_d = '0;
      end
    end else begin
      if (lead_ev) begin
        act_d  = 1'b1;
        lead_d = 1'b1;
      end
      if (trail_ev) begin
        act_d    = 1'b0;
        trail_d  = 1'b1;
        done_d   = last_pulse;
        cnt_d    = last_pulse ? '0 : cnt_q + 1'b1;
        stop_now = fr_q ? ~framed : last_pulse;
        if (stop_now) begin
          run_d = 1'b0;
          fr_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q   <= 1'b0;
      fr_q    <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      fr_q    <= fr_d;
      act_q   <= act_d;
      cnt_q   <= cnt_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
      done_q  <= done_d;
    end
  end

  assign sck_out   = (act_q & ~ext_clk_en) ^ cpol;
  assign sck_oe    = ~ext_clk_en;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;
  assign word_done = done_q;
  assign busy      = run_q;
endmodule

// File: rtl/sck_prescaler_chk.sv
`timescale 1ns/1ps
module sck_prescaler_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic halt,
  input logic sck_out,
  input logic sck_oe,
  input logic lead_stb,
  input logic trail_stb,
  input logic word_done,
  input logic busy
);
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_out == cpol));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R3
  lead_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb && sck_oe) |-> (sck_out != cpol));

  // R3
  trail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_stb && sck_oe) |-> (sck_out == cpol));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> (!busy && !lead_stb && !trail_stb && !word_done));

  // R10
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_oe |-> (sck_out == cpol));

  // R5
  done_on_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> trail_stb);
endmodule

bind sck_prescaler sck_prescaler_chk u_chk (.*);

// File: tb/sck_prescaler_bench.sv
`timescale 1ns/1ps
module sck_prescaler_bench;
  logic       clk, rst_n;
  logic [1:0] pri_code;
  logic [2:0] sec_code;
  logic       cpol, word16, start, framed, halt, ext_clk_en, sck_in;
  logic       sck_out, sck_oe, lead_stb, trail_stb, word_done, busy;
  int n_chk, n_fail, n_overlap;

  sck_prescaler u_sck_prescaler (
    .clk(clk), .rst_n(rst_n), .pri_code(pri_code), .sec_code(sec_code),
    .cpol(cpol), .word16(word16), .start(start), .framed(framed),
    .halt(halt), .ext_clk_en(ext_clk_en), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .lead_stb(lead_stb),
    .trail_stb(trail_stb), .word_done(word_done), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input int pri, input int sec);
    int n;
    n = (1 << (2 * (3 - pri))) * (8 - sec);
    return (n == 1) ? 2 : n;
  endfunction

  task automatic sample_ovl();
    if (lead_stb && trail_stb) n_overlap++;
  endtask

  // one gated word, full timeline compared cycle by cycle (R1 R3 R5)
  task automatic run_word(input int pri, input int sec, input bit cp, input bit w16,
                          input int poke, input string tag);
    int n, h, b, last, bad;
    bit el, et, es, ed, eb;
    n = period(pri, sec);
    h = n / 2;
    b = w16 ? 16 : 8;
    last = (b - 1) * n + h + 1;
    bad = 0;
    @(negedge clk);
    pri_code = 2'(pri); sec_code = 3'(sec); cpol = cp; word16 = w16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= last + 1; c++) begin
      int m;
      @(negedge clk);
      sample_ovl();
      m = (c - 1) % n;
      if (c <= last) begin
        el = (m == 0); et = (m == h); es = (m < h) ^ cp;
        ed = (c == last); eb = (c < last);
      end else begin
        el = 0; et = 0; es = cp; ed = 0; eb = 0;
      end
      if (lead_stb !== el || trail_stb !== et || sck_out !== es ||
          word_done !== ed || busy !== eb) bad++;
      start = (poke != 0 && c == poke);
    end
    start = 1'b0;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int n, h, b, cs, bad, leads, trails, dones;
    n_chk = 0; n_fail = 0; n_overlap = 0;
    rst_n = 1'b0; pri_code = 2'd3; sec_code = 3'd7; cpol = 1'b0; word16 = 1'b0;
    start = 1'b0; framed = 1'b0; halt = 1'b0; ext_clk_en = 1'b0; sck_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4 reset state
    chk(sck_out == 1'b0 && sck_oe && !busy && !lead_stb && !trail_stb && !word_done,
        "R4 reset state", {sck_out, sck_oe, busy, lead_stb, trail_stb, word_done}, 6'b010000);

    // R1 R2 R3 sweep of every ratio code, both polarities
    for (int cp = 0; cp < 2; cp++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 8; s++)
          run_word(p, s, cp[0], 1'b0, 0, (p == 3 && s == 7) ? "R2 minimum ratio" : "R1/R3 ratio timeline");

    // R5 sixteen-pulse words
    for (int p = 1; p < 4; p++)
      for (int s = 0; s < 8; s++)
        run_word(p, s, 1'b0, 1'b1, 0, "R5 sixteen-pulse word");

    // R6 start during a busy word
    run_word(2, 6, 1'b1, 1'b0, 13, "R6 start while busy");
    run_word(1, 5, 1'b0, 1'b0, 40, "R6 start while busy");

    // R8 halt mid-word, start ignored while halted
    @(negedge clk);
    pri_code = 2'd2; sec_code = 3'd6; cpol = 1'b0; word16 = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 1; c <= 10; c++) begin @(negedge clk); sample_ovl(); end
    halt = 1'b1;
    @(negedge clk);
    chk(!busy && sck_out == 1'b0 && !lead_stb && !trail_stb && !word_done,
        "R8 idle after halt", {busy, sck_out, lead_stb, trail_stb, word_done}, 0);
    start = 1'b1;
    bad = 0;
    for (int c = 0; c < 2; c++) begin @(negedge clk); if (busy || lead_stb) bad++; end
    halt = 1'b0; start = 1'b0;
    chk(bad == 0, "R8 start ignored in halt", bad, 0);
    run_word(2, 6, 1'b0, 1'b0, 0, "R8 fresh word after halt");

    // R9 halt coincides with the final trailing edge (N=8, H=4, last=61)
    @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 1; c <= 60; c++) begin @(negedge clk); sample_ovl(); end
    halt = 1'b1;
    bad = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (trail_stb || word_done || busy) bad++;
    end
    halt = 1'b0;
    chk(bad == 0, "R9 halt beats final edge", bad, 0);

    // R7 framed run, N=4 H=2, 8-pulse words, stop after framed drops
    n = 4; h = 2; b = 8; bad = 0; cs = 0;
    @(negedge clk);
    pri_code = 2'd2; sec_code = 3'd7; cpol = 1'b1; word16 = 1'b0; framed = 1'b1;
    @(negedge clk);
    for (int c = 1; c <= 200; c++) begin
      int m, k;
      bit el, et, es, ed, eb;
      @(negedge clk);
      sample_ovl();
      m = (c - 1) % n; k = (c - 1) / n;
      if (cs == 0 && c >= 102 && m == h) cs = c;
      if (cs == 0 || c <= cs) begin
        el = (m == 0) && (cs == 0 || c < cs); et = (m == h);
        es = ((m < h) && (cs == 0 || c < cs)) ^ 1'b1;
        ed = (m == h) && (k % b == b - 1); eb = (cs == 0 || c < cs);
      end else begin
        el = 0; et = 0; es = 1'b1; ed = 0; eb = 0;
      end
      if (lead_stb !== el || trail_stb !== et || sck_out !== es ||
          word_done !== ed || busy !== eb) bad++;
      if (c == 100) framed = 1'b0;
      if (cs != 0 && c >= cs + 6) break;
    end
    chk(bad == 0, "R7 framed timeline", bad, 0);
    chk(cs == 103, "R7 stop cycle", cs, 103);

    // R10 R11 external clock, both polarities
    for (int cp = 0; cp < 2; cp++) begin
      @(negedge clk);
      ext_clk_en = 1'b1; cpol = cp[0]; sck_in = cp[0]; word16 = 1'b0;
      leads = 0; trails = 0; bad = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (lead_stb || trail_stb) leads++;
        if (sck_oe || sck_out !== cp[0]) bad++;
        if (c >= 4 && c < 28 && c % 4 == 0) sck_in = ~sck_in;
      end
      chk(leads == 0, "R11 idle edges ignored", leads, 0);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      leads = 0; trails = 0; dones = 0;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk);
        sample_ovl();
        if (lead_stb) leads++;
        if (trail_stb) trails++;
        if (word_done) dones++;
        if (sck_oe || sck_out !== cp[0]) bad++;
        if (c >= 1 && c < 65 && (c - 1) % 4 == 0) sck_in = ~sck_in;
      end
      chk(leads == 8, "R10 external leading strobes", leads, 8);
      chk(trails == 8, "R10 external trailing strobes", trails, 8);
      chk(dones == 1 && !busy, "R10 external word done", dones, 1);
      chk(bad == 0, "R10 drive off and level held", bad, 0);
      ext_clk_en = 1'b0;
    end

    chk(n_overlap == 0, "R12 strobe overlap", n_overlap, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule